// File: doc/BRIEF.md
# Access Fault Interrupt and Response Controller

This block gathers access-violation events from up to four address filter units. Each filter reports two kinds of event: a permission failure and a region-overlap error. For every filter the block keeps three sticky flags. The status flag records that at least one fault occurred. The overrun flag records that a further fault arrived before software cleared the status. The overlap flag records that one of the faults was an overlap error. Software reads all flags in one 32-bit word and clears them per filter with a write-one-to-clear register.

A 2-bit action setting shapes the block's reaction. Its upper bit lets pending status drive the single interrupt line. Its lower bit turns the bus response of each faulting access from OKAY into DECERR. The error-response flag is raised in the very cycle of the fault, so the filter can return it on the access that failed. The flags are kept whatever the action setting is. The interrupt enable therefore only gates the line and never hides the history.

Register port (word offsets): 0 = action setting (read/write, bits [1:0]), 1 = fault status word (read only), 2 = clear register (write only, reads zero), 3 = reserved (reads zero). Read data is registered.

Top module: `access_fault_ctrl`

## Requirements
- R1: After reset the status word reads 0, the action setting reads 0, `irq` is low and every `resp_decerr` bit is low.
- R2: The status word holds per-filter status in bits [3:0], overrun in bits [11:8] and overlap in bits [19:16], with bit n of each field belonging to filter n. All other bits, and the bits of filters at or above `NUM_FILT`, read 0.
- R3: A permission failure or overlap event at filter n sets its status bit on the next clock edge, whatever the action setting.
- R4: An event at filter n while its status bit is already set (and not cleared in that cycle) sets its overrun bit.
- R5: An overlap event at filter n sets both its overlap bit and its status bit.
- R6: Writing the clear register with bit n = 1 clears status, overrun and overlap of filter n together. Bits that are 0, and bits at or above `NUM_FILT`, leave the flags unchanged.
- R7: When an event and a clear for the same filter fall in the same cycle, the event wins. Status ends set, overrun ends clear, and overlap ends set only if that event was an overlap.
- R8: `irq` is high exactly when action bit 1 is set and at least one status bit is set. It follows the registered flags, one edge after the event.
- R9: `resp_decerr[n]` is high in the same cycle as an event at filter n when action bit 0 is set. It is low otherwise.
- R10: The action setting stores bits [1:0] of a write to offset 0, and its other bits read 0. Writes to the status word are ignored. `reg_rdata` presents the addressed register one edge after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_fail | input | NUM_FILT | Per-filter permission failure pulse |
| ovl_fail | input | NUM_FILT | Per-filter region overlap error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Fault interrupt line |
| resp_decerr | output | NUM_FILT | Same-cycle DECERR request per filter |

## Verification
The error-response flag is combinational, so the bench samples it in the same low clock phase in which it drives the fault. The flags and `irq` change on the first rising edge after an event or a clear, so they are checked at the following falling edge. A status read costs one more edge because `reg_rdata` is registered. The vector loop therefore applies each stimulus for one full cycle and then issues a read. It compares `reg_rdata` and `irq` one falling edge later, when both have settled. Faults that arrive in the same cycle as a clear are driven within a single cycle, so their priority shows up at the ports.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_FILT  = 4;
   localparam int unsigned ACT_W     = 2;

   // field positions in the status word (software decodes these)
   localparam int unsigned STAT_LSB  = 0;
   localparam int unsigned OVRN_LSB  = 8;
   localparam int unsigned OVLP_LSB  = 16;

   // register word offsets
   typedef enum logic [1:0] {
      OFS_ACTION = 2'd0,
      OFS_STATUS = 2'd1,
      OFS_CLEAR  = 2'd2,
      OFS_RSVD   = 2'd3
   } reg_ofs_e;

   typedef struct packed {
      logic irq_en;     // action bit 1
      logic decerr_en;  // action bit 0
   } action_t;

   typedef struct packed {
      logic stat;
      logic ovrn;
      logic ovlp;
   } flt_flags_t;

endpackage

// File: rtl/fault_flag_track.sv
module fault_flag_track
   import fault_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       perm_evt,
   input  logic       ovlp_evt,
   input  logic       clr,
   output flt_flags_t flags
);

   flt_flags_t flags_q;
   flt_flags_t base;
   flt_flags_t flags_d;
   logic       any_evt;

   assign any_evt = perm_evt | ovlp_evt;

   always_comb begin
      base    = clr ? '0 : flags_q;
      flags_d.stat = base.stat | any_evt;
      flags_d.ovrn = base.ovrn | (any_evt & base.stat);
      flags_d.ovlp = base.ovlp | ovlp_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags = flags_q;

   p_evt_sets_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_evt || ovlp_evt) |=> flags_q.stat);

   p_second_evt_ovrn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((perm_evt || ovlp_evt) && flags_q.stat && !clr) |=> flags_q.ovrn);

   p_ovlp_has_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.ovlp |-> flags_q.stat);

   p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !perm_evt && !ovlp_evt) |=> (flags_q == '0));

   p_evt_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (perm_evt || ovlp_evt)) |=> (flags_q.stat && !flags_q.ovrn));

endmodule

// File: rtl/fault_regfile.sv
module fault_regfile
   import fault_irq_pkg::*;
#(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [NUM_FILT-1:0] stat_vec,
   input  logic [NUM_FILT-1:0] ovrn_vec,
   input  logic [NUM_FILT-1:0] ovlp_vec,
   output action_t             action,
   output logic [NUM_FILT-1:0] clr_vec,
   output logic [DATA_W-1:0]   reg_rdata
);

   localparam int unsigned OFS_W = $bits(reg_ofs_e);

   action_t          act_q;
   logic [WORD_W-1:0] status_word;
   logic [WORD_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   reg_ofs_e         ofs;

   assign ofs = reg_ofs_e'(reg_addr[OFS_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              act_q <= '0;
      else if (reg_wr && ofs == OFS_ACTION)    act_q <= action_t'(reg_wdata[ACT_W-1:0]);
   end

   assign clr_vec = (reg_wr && ofs == OFS_CLEAR) ? reg_wdata[NUM_FILT-1:0] : '0;

   always_comb begin
      status_word = '0;
      for (int i = 0; i < NUM_FILT; i++) begin
         status_word[STAT_LSB + i] = stat_vec[i];
         status_word[OVRN_LSB + i] = ovrn_vec[i];
         status_word[OVLP_LSB + i] = ovlp_vec[i];
      end
   end

   always_comb begin
      unique case (ofs)
         OFS_ACTION: rd_mux = {{(WORD_W-ACT_W){1'b0}}, act_q};
         OFS_STATUS: rd_mux = status_word;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux[DATA_W-1:0];
   end

   assign action    = act_q;
   assign reg_rdata = rdata_q;

   p_action_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && ofs == OFS_ACTION) |=> $stable(act_q));

   p_clear_only_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |-> (clr_vec == '0));

endmodule

// File: rtl/access_fault_ctrl.sv
module access_fault_ctrl
   import fault_irq_pkg::*;
#(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FILT-1:0] perm_fail,
   input  logic [NUM_FILT-1:0] ovl_fail,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq,
   output logic [NUM_FILT-1:0] resp_decerr
);

   initial begin
      assert (NUM_FILT >= 1 && NUM_FILT <= MAX_FILT)
         else $fatal(1, "NUM_FILT out of range");
      assert (DATA_W == WORD_W)
         else $fatal(1, "DATA_W must equal status word width");
      assert (ADDR_W >= $bits(reg_ofs_e))
         else $fatal(1, "ADDR_W too small");
   end

   action_t             action;
   logic [NUM_FILT-1:0] clr_vec;
   logic [NUM_FILT-1:0] stat_vec;
   logic [NUM_FILT-1:0] ovrn_vec;
   logic [NUM_FILT-1:0] ovlp_vec;

   for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
      flt_flags_t fl;
      fault_flag_track i_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .perm_evt (perm_fail[g]),
         .ovlp_evt (ovl_fail[g]),
         .clr      (clr_vec[g]),
         .flags    (fl)
      );
      assign stat_vec[g]    = fl.stat;
      assign ovrn_vec[g]    = fl.ovrn;
      assign ovlp_vec[g]    = fl.ovlp;
      assign resp_decerr[g] = action.decerr_en & (perm_fail[g] | ovl_fail[g]);
   end

   fault_regfile #(
      .NUM_FILT (NUM_FILT),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .stat_vec  (stat_vec),
      .ovrn_vec  (ovrn_vec),
      .ovlp_vec  (ovlp_vec),
      .action    (action),
      .clr_vec   (clr_vec),
      .reg_rdata (reg_rdata)
   );

   assign irq = action.irq_en & (|stat_vec);

   p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (action.irq_en && (|stat_vec)) |-> irq);

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !action.irq_en |-> !irq);

   p_no_resp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((perm_fail | ovl_fail) == '0) |-> (resp_decerr == '0));

endmodule

// File: tb/test_access_fault_ctrl.sv
module test_access_fault_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NF = 4;
   localparam int NVEC = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] perm_fail = '0;
   logic [NF-1:0] ovl_fail = '0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;
   logic [NF-1:0] resp_decerr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   access_fault_ctrl #(.NUM_FILT(NF)) i_access_fault_ctrl (
      .clk(clk), .rst_n(rst_n), .perm_fail(perm_fail), .ovl_fail(ovl_fail),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .resp_decerr(resp_decerr)
   );

   // {perm[3:0], ovl[3:0], clr_en, clr_data[7:0], expected status word}
   localparam logic [48:0] VEC [NVEC] = '{
      {4'b0001, 4'b0000, 1'b0, 8'h00, 32'h0000_0001},  // R3
      {4'b0001, 4'b0000, 1'b0, 8'h00, 32'h0000_0101},  // R4
      {4'b0000, 4'b0100, 1'b0, 8'h00, 32'h0004_0105},  // R5
      {4'b0000, 4'b0000, 1'b1, 8'h01, 32'h0004_0004},  // R6
      {4'b1010, 4'b0000, 1'b0, 8'h00, 32'h0004_000E},  // R3
      {4'b0000, 4'b0100, 1'b0, 8'h00, 32'h0004_040E},  // R4 overlap as second fault
      {4'b0000, 4'b0000, 1'b1, 8'h00, 32'h0004_040E},  // R6 zeros no effect
      {4'b0010, 4'b0000, 1'b0, 8'h00, 32'h0004_060E},  // R4
      {4'b0010, 4'b0000, 1'b1, 8'h02, 32'h0004_040E},  // R7
      {4'b0000, 4'b0000, 1'b1, 8'hF4, 32'h0000_000A},  // R6 high bits ignored
      {4'b0000, 4'b0000, 1'b1, 8'h0A, 32'h0000_0000},  // R6
      {4'b0000, 4'b0001, 1'b1, 8'h01, 32'h0001_0001},  // R7 overlap
      {4'b0000, 4'b0000, 1'b1, 8'h0F, 32'h0000_0000}   // R6
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 resp", {28'b0, resp_decerr}, 32'h0);
      rst_n = 1'b1;
      reg_read(2'd1, rd); check("R1 status", rd, 32'h0);
      reg_read(2'd0, rd); check("R1 action", rd, 32'h0);

      // R10 action width, R8 enable irq
      reg_write(2'd0, 32'hFFFF_FFFE);
      reg_read(2'd0, rd); check("R10 action", rd, 32'h2);

      // vector walk: R2..R8
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         perm_fail = VEC[i][48:45];
         ovl_fail  = VEC[i][44:41];
         reg_wr    = VEC[i][40];
         reg_addr  = 2'd2;
         reg_wdata = {24'b0, VEC[i][39:32]};
         @(negedge clk);
         perm_fail = '0; ovl_fail = '0; reg_wr = 1'b0; reg_wdata = '0;
         check("R8 irq", {31'b0, irq}, {31'b0, (VEC[i][3:0] != 4'h0)});
         reg_read(2'd1, rd);
         check($sformatf("R2 vector %0d", i), rd, VEC[i][31:0]);
      end

      // R3: flags recorded with irq disabled, R8 irq stays low
      reg_write(2'd0, 32'h0);
      @(negedge clk); perm_fail = 4'b1000;
      check("R9 no decerr", {28'b0, resp_decerr}, 32'h0);
      @(negedge clk); perm_fail = '0;
      check("R8 masked", {31'b0, irq}, 32'h0);
      reg_read(2'd1, rd); check("R3 silent", rd, 32'h0000_0008);

      // R10 status write ignored
      reg_write(2'd1, 32'hFFFF_FFFF);
      reg_read(2'd1, rd); check("R10 status ro", rd, 32'h0000_0008);
      reg_read(2'd2, rd); check("R10 clear reads 0", rd, 32'h0);

      // R9 same-cycle DECERR
      reg_write(2'd0, 32'h1);
      @(negedge clk); perm_fail = 4'b0010; ovl_fail = 4'b0100;
      #1;
      check("R9 decerr", {28'b0, resp_decerr}, 32'h6);
      @(negedge clk); perm_fail = '0; ovl_fail = '0;
      #1;
      check("R9 drop", {28'b0, resp_decerr}, 32'h0);
      reg_read(2'd1, rd); check("R5 after decerr", rd, 32'h0004_000E);

      // R8 enabling irq with pending status raises it
      reg_write(2'd0, 32'h3);
      check("R8 late enable", {31'b0, irq}, 32'h1);
      reg_write(2'd2, 32'hF);
      check("R8 cleared", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule